// File: doc/BRIEF.md
# Dual-Bank Dynamic Clock Generator Control

This block steers a fractional clock generator that owns two full configuration banks. Each bank holds a source code, a pre-divider and an M/N ratio. A single select bit decides which bank drives the generated output, a train of single-cycle enable pulses in the system clock domain. The clock sources are modelled as enable pulses in that same domain.

A request port takes a source index, a divisor and an M/N pair. A short sequencer places the request in the right bank. When the output is enabled, the request goes into the idle bank while the active bank keeps running, and the select bit then flips once. The flip waits for a cycle in which both bank outputs are low, so the output never carries a clipped pulse. When the output is disabled, the request rewrites the selected bank in place and the select bit stays as it is. A readback port always shows the active bank's settings in request terms (source index, divisor, M, N).

Top module: `dyn_clkgen_ctrl`

## Requirements
- R1: After a synchronous active-high reset, bank 0 is active, busy and both bank holds are low, and the readback shows source 0, divisor 1, M 0 and N 0.
- R2: A request accepted while `out_en` is high is written into the inactive bank. During the sequence the readback keeps showing the previous settings. When busy falls, `active_bank` has inverted and the readback shows the new settings.
- R3: A request accepted while `out_en` is low is written into the currently selected bank, and `active_bank` is unchanged when busy falls.
- R4: During a sequence, only the target bank's hold bit (`bank_hold[tgt]`) is asserted. It is released no later than the cycle busy falls, and a held bank emits no output pulse.
- R5: Source indices 0..4 each map to a per-bank hardware code, and readback translates the code back to the index. An index of 5 or more stores a code absent from both tables, which reads back as source 0 and produces no output pulses.
- R6: The bank stores the divisor minus one, so a requested divisor of 1..16 reads back unchanged. One prescaled tick occurs per that many selected source pulses.
- R7: A request with N = 0 selects bypass. In bypass, M reads back as 0 and every prescaled tick yields one output pulse.
- R8: With 0 < M <= N, the output carries M pulses per N prescaled ticks on average.
- R9: The select bit changes only in a cycle that follows a cycle with both bank outputs low.
- R10: Busy rises on the edge that accepts a request and stays high until the sequence ends. A request that arrives while busy is dropped and answered by a one-cycle `wr_rej` pulse on the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| out_en | input | 1 | Output currently enabled; sampled when a request is accepted |
| wr_req | input | 1 | One-cycle configuration request |
| wr_src | input | 3 | Requested source index |
| wr_div | input | 5 | Requested pre-divider, 1..16 |
| wr_m | input | 8 | Requested M value |
| wr_n | input | 8 | Requested N value, 0 selects bypass |
| src_pulse | input | 5 | Enable pulse of each clock source |
| busy | output | 1 | Update sequence in progress |
| wr_rej | output | 1 | Request dropped because busy |
| active_bank | output | 1 | Bank currently driving the output |
| bank_hold | output | 2 | Counter hold of each bank |
| clk_pulse | output | 1 | Generated output enable pulse |
| rd_src | output | 3 | Active bank source index |
| rd_div | output | 5 | Active bank divisor |
| rd_m | output | 8 | Active bank M |
| rd_n | output | 8 | Active bank N |

## Verification
A select bit left pointing at the wrong bank shows up at the readback ports on the first idle cycle after busy falls, as the previous or a stale configuration. A source code stored or decoded wrongly appears as a wrong `rd_src` at that same moment. A wrong pulse rate appears as a pulse count that drifts from the computed ratio within a few hundred cycles. A bank that is left in hold, or released too early, shows at `bank_hold` during the sequence. A sequencer that never leaves its final state keeps busy high, which the bench's bounded wait catches.

// File: rtl/cgen_pkg.sv
package cgen_pkg;

    localparam int CG_NSRC = 5;   // number of clock sources
    localparam int CG_IW   = 3;   // source index width
    localparam int CG_CW   = 3;   // stored source code width
    localparam int CG_PW   = 4;   // pre-divider field width
    localparam int CG_MW   = 8;   // M/N width
    localparam int CG_NB   = 2;   // number of banks

    localparam logic [CG_IW-1:0] CG_NSRC_I    = CG_IW'(CG_NSRC);
    localparam logic [CG_CW-1:0] CG_CODE_NONE = '0;

    typedef struct packed {
        logic [CG_CW-1:0] code;
        logic [CG_PW-1:0] div_m1;
        logic [CG_MW-1:0] m;
        logic [CG_MW-1:0] n;
    } bank_cfg_t;

    typedef struct packed {
        logic [CG_IW-1:0] idx;
        logic [CG_PW-1:0] div_m1;
        logic [CG_MW-1:0] m;
        logic [CG_MW-1:0] n;
    } cfg_req_t;

    typedef enum logic [2:0] {
        SQ_IDLE,
        SQ_HOLD,
        SQ_MN,
        SQ_PS,
        SQ_FIN
    } seq_st_t;

    // Per-bank mapping from source index to hardware code; bank 1 is rotated.
    function automatic logic [CG_CW-1:0] src_encode(input logic bank,
                                                    input logic [CG_IW-1:0] idx);
        int rot;
        if (idx >= CG_NSRC_I) return CG_CODE_NONE;
        rot = (int'(idx) + (bank ? 2 : 0)) % CG_NSRC;
        return CG_CW'(rot + 1);
    endfunction

    // Reverse mapping; a code missing from the table yields index 0.
    function automatic logic [CG_IW-1:0] src_decode(input logic bank,
                                                    input logic [CG_CW-1:0] code);
        for (int i = 0; i < CG_NSRC; i++)
            if (src_encode(bank, CG_IW'(i)) == code) return CG_IW'(i);
        return '0;
    endfunction

endpackage

// File: rtl/cgen_bank_rf.sv
module cgen_bank_rf
    import cgen_pkg::*;
(
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    tgt,
    input  logic                    we_mn,
    input  logic                    we_ps,
    input  cfg_req_t                req,
    output bank_cfg_t [CG_NB-1:0]   cfg
);

    for (genvar b = 0; b < CG_NB; b++) begin : g_bank
        bank_cfg_t r;
        always_ff @(posedge clk) begin
            if (rst) begin
                r.code   <= src_encode(1'(b), '0);
                r.div_m1 <= '0;
                r.m      <= '0;
                r.n      <= '0;
            end else if (tgt == 1'(b)) begin
                if (we_mn) begin
                    r.m <= req.m;
                    r.n <= req.n;
                end
                if (we_ps) begin
                    r.code   <= src_encode(1'(b), req.idx);
                    r.div_m1 <= req.div_m1;
                end
            end
        end
        assign cfg[b] = r;
    end

endmodule

// File: rtl/cgen_bank_div.sv
module cgen_bank_div
    import cgen_pkg::*;
#(
    parameter bit BANK = 1'b0
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               hold,
    input  bank_cfg_t          cfg,
    input  logic [CG_NSRC-1:0] src_pulse,
    output logic               lvl
);

    logic [CG_IW-1:0]   idx;
    logic               valid;
    logic [CG_NSRC-1:0] shifted;
    logic               pulse;
    logic               ptick;
    logic [CG_PW-1:0]   pcnt;
    logic [CG_MW-1:0]   acc;
    logic [CG_MW:0]     sum;

    always_comb begin
        idx     = src_decode(BANK, cfg.code);
        valid   = (src_encode(BANK, idx) == cfg.code);
        shifted = src_pulse >> idx;
        pulse   = valid & shifted[0];
        ptick   = pulse && (pcnt == cfg.div_m1);
        sum     = {1'b0, acc} + {1'b0, cfg.m};
    end

    always_ff @(posedge clk) begin
        if (rst || hold) begin
            pcnt <= '0;
            acc  <= '0;
            lvl  <= 1'b0;
        end else begin
            lvl <= 1'b0;
            if (pulse) pcnt <= ptick ? '0 : pcnt + 1'b1;
            if (ptick) begin
                if (cfg.n == '0) begin
                    lvl <= 1'b1;
                end else if (sum >= {1'b0, cfg.n}) begin
                    acc <= CG_MW'(sum - {1'b0, cfg.n});
                    lvl <= 1'b1;
                end else begin
                    acc <= CG_MW'(sum);
                end
            end
        end
    end

    // R4: a held bank stays silent
    p_hold_quiet_r4: assert property (@(posedge clk) disable iff (rst)
        hold |=> !lvl);

    // R6: prescale count never passes the stored divisor-minus-one
    p_div_bound_r6: assert property (@(posedge clk) disable iff (rst)
        !hold |=> (pcnt <= cfg.div_m1) || $past(!$stable(cfg)));

endmodule

// File: rtl/cgen_seq.sv
module cgen_seq
    import cgen_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            wr_req,
    input  logic            out_en,
    input  cfg_req_t        req_in,
    input  logic            both_low,
    output logic            busy,
    output logic            rej,
    output logic            sel,
    output logic            tgt,
    output logic [CG_NB-1:0] hold,
    output logic            we_mn,
    output logic            we_ps,
    output cfg_req_t        req_q
);

    seq_st_t st;
    logic    swap;

    assign we_mn = (st == SQ_MN);
    assign we_ps = (st == SQ_PS);

    always_ff @(posedge clk) begin
        if (rst) begin
            st    <= SQ_IDLE;
            busy  <= 1'b0;
            rej   <= 1'b0;
            sel   <= 1'b0;
            tgt   <= 1'b0;
            swap  <= 1'b0;
            hold  <= '0;
            req_q <= '0;
        end else begin
            rej <= wr_req && busy;
            case (st)
                SQ_IDLE: if (wr_req) begin
                    req_q <= req_in;
                    swap  <= out_en;
                    tgt   <= out_en ? ~sel : sel;
                    busy  <= 1'b1;
                    st    <= SQ_HOLD;
                end
                SQ_HOLD: begin
                    hold[tgt] <= 1'b1;
                    st        <= SQ_MN;
                end
                SQ_MN:   st <= SQ_PS;
                SQ_PS:   st <= SQ_FIN;
                SQ_FIN: if (!swap || both_low) begin
                    hold <= '0;
                    if (swap) sel <= ~sel;
                    busy <= 1'b0;
                    st   <= SQ_IDLE;
                end
                default: st <= SQ_IDLE;
            endcase
        end
    end

    // R10: a request while busy is answered by a reject pulse
    p_reject_r10: assert property (@(posedge clk) disable iff (rst)
        (wr_req && busy) |=> rej);

    // R2: the select bit moves only as a sequence completes
    p_sel_at_done_r2: assert property (@(posedge clk) disable iff (rst)
        !$stable(sel) |-> $fell(busy));

    // R4: no hold outside a sequence, at most one bank held
    p_hold_idle_r4: assert property (@(posedge clk) disable iff (rst)
        !busy |-> (hold == '0));
    p_single_hold_r4: assert property (@(posedge clk) disable iff (rst)
        $onehot0(hold));

    // R9: flip only after a cycle where both bank outputs were low
    p_swap_low_r9: assert property (@(posedge clk) disable iff (rst)
        !$stable(sel) |-> $past(both_low));

endmodule

// File: rtl/dyn_clkgen_ctrl.sv
module dyn_clkgen_ctrl
    import cgen_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               out_en,
    input  logic               wr_req,
    input  logic [CG_IW-1:0]   wr_src,
    input  logic [CG_PW:0]     wr_div,
    input  logic [CG_MW-1:0]   wr_m,
    input  logic [CG_MW-1:0]   wr_n,
    input  logic [CG_NSRC-1:0] src_pulse,
    output logic               busy,
    output logic               wr_rej,
    output logic               active_bank,
    output logic [CG_NB-1:0]   bank_hold,
    output logic               clk_pulse,
    output logic [CG_IW-1:0]   rd_src,
    output logic [CG_PW:0]     rd_div,
    output logic [CG_MW-1:0]   rd_m,
    output logic [CG_MW-1:0]   rd_n
);

    cfg_req_t              req_in;
    cfg_req_t              req_q;
    bank_cfg_t [CG_NB-1:0] cfg;
    bank_cfg_t             act;
    logic [CG_NB-1:0]      lvl;
    logic                  tgt;
    logic                  we_mn;
    logic                  we_ps;
    logic                  sel;

    always_comb begin
        req_in.idx    = wr_src;
        req_in.div_m1 = CG_PW'(wr_div - 1'b1);
        req_in.n      = wr_n;
        req_in.m      = (wr_n == '0) ? '0 : wr_m;
    end

    cgen_seq u_seq (
        .clk      (clk),
        .rst      (rst),
        .wr_req   (wr_req),
        .out_en   (out_en),
        .req_in   (req_in),
        .both_low (~|lvl),
        .busy     (busy),
        .rej      (wr_rej),
        .sel      (sel),
        .tgt      (tgt),
        .hold     (bank_hold),
        .we_mn    (we_mn),
        .we_ps    (we_ps),
        .req_q    (req_q)
    );

    cgen_bank_rf u_rf (
        .clk   (clk),
        .rst   (rst),
        .tgt   (tgt),
        .we_mn (we_mn),
        .we_ps (we_ps),
        .req   (req_q),
        .cfg   (cfg)
    );

    for (genvar b = 0; b < CG_NB; b++) begin : g_div
        cgen_bank_div #(.BANK(1'(b))) u_div (
            .clk       (clk),
            .rst       (rst),
            .hold      (bank_hold[b]),
            .cfg       (cfg[b]),
            .src_pulse (src_pulse),
            .lvl       (lvl[b])
        );
    end

    always_comb begin
        act         = cfg[sel];
        active_bank = sel;
        clk_pulse   = lvl[sel];
        rd_src      = src_decode(sel, act.code);
        rd_div      = (CG_PW+1)'(act.div_m1) + (CG_PW+1)'(1);
        rd_m        = act.m;
        rd_n        = act.n;
    end

endmodule

// File: tb/dyn_clkgen_ctrl_tb_top.sv
`timescale 1ns/1ps
module dyn_clkgen_ctrl_tb_top;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       out_en = 1'b0;
    logic       wr_req = 1'b0;
    logic [2:0] wr_src = '0;
    logic [4:0] wr_div = 5'd1;
    logic [7:0] wr_m = '0;
    logic [7:0] wr_n = '0;
    logic [4:0] src_pulse = '0;
    logic       busy, wr_rej, active_bank, clk_pulse;
    logic [1:0] bank_hold;
    logic [2:0] rd_src;
    logic [4:0] rd_div;
    logic [7:0] rd_m, rd_n;

    int n_chk = 0;
    int n_fail = 0;
    int pcnt = 0;
    logic exp_bank = 1'b0;
    int   exp_src = 0, exp_div = 1, exp_m = 0, exp_n = 0;

    always #2.5 clk = ~clk;

    dyn_clkgen_ctrl dut_i (
        .clk(clk), .rst(rst), .out_en(out_en), .wr_req(wr_req),
        .wr_src(wr_src), .wr_div(wr_div), .wr_m(wr_m), .wr_n(wr_n),
        .src_pulse(src_pulse), .busy(busy), .wr_rej(wr_rej),
        .active_bank(active_bank), .bank_hold(bank_hold),
        .clk_pulse(clk_pulse), .rd_src(rd_src), .rd_div(rd_div),
        .rd_m(rd_m), .rd_n(rd_n)
    );

    // Source k pulses once every k+2 cycles
    always @(negedge clk) begin
        pcnt = pcnt + 1;
        for (int k = 0; k < 5; k++) src_pulse[k] = ((pcnt % (k + 2)) == 0);
    end

    task automatic check(input int got, input int exp, input string what);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %0d expected %0d", what, got, exp);
        end
    endtask

    task automatic report();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    task automatic check_readback(input string tag);
        check(int'(active_bank), int'(exp_bank), {tag, " active bank"});
        check(int'(rd_src), exp_src, {tag, " source index"});
        check(int'(rd_div), exp_div, {tag, " divisor"});
        check(int'(rd_m), exp_m, {tag, " M"});
        check(int'(rd_n), exp_n, {tag, " N"});
    endtask

    task automatic do_write(input logic en, input int idx, input int div,
                            input int m, input int n);
        logic [1:0] seen;
        logic       tgt;
        int         waitc;
        out_en = en;
        wr_src = 3'(idx); wr_div = 5'(div); wr_m = 8'(m); wr_n = 8'(n);
        wr_req = 1'b1;
        tgt = en ? ~exp_bank : exp_bank;
        @(negedge clk);
        wr_req = 1'b0;
        check(int'(busy), 1, "R10 busy after accepted request");
        if (en) check(int'(rd_src), exp_src, "R2 old source visible while busy");
        if (en) check(int'(rd_div), exp_div, "R2 old divisor visible while busy");
        seen = '0;
        waitc = 0;
        while (busy && waitc < 500) begin
            seen |= bank_hold;
            @(negedge clk);
            waitc++;
        end
        check(int'(busy), 0, "R10 sequence completes");
        check(int'(seen[tgt]), 1, "R4 target bank held");
        check(int'(seen[~tgt]), 0, "R4 other bank never held");
        check(int'(bank_hold), 0, "R4 hold released at completion");
        exp_bank = tgt;
        exp_src  = (idx < 5) ? idx : 0;
        exp_div  = div;
        exp_n    = n;
        exp_m    = (n == 0) ? 0 : m;
        check_readback(en ? "R2" : "R3");
    endtask

    task automatic count_pulses(input int w, output int c);
        c = 0;
        for (int i = 0; i < w; i++) begin
            @(negedge clk);
            if (clk_pulse) c++;
        end
    endtask

    task automatic check_rate(input int w, input int expc, input string what);
        int c;
        count_pulses(w, c);
        n_chk++;
        if (c < expc - 2 || c > expc + 2) begin
            n_fail++;
            $display("FAIL %s: got %0d expected %0d", what, c, expc);
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        report();
    end

    initial begin
        int c;
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        check(int'(busy), 0, "R1 busy after reset");
        check(int'(bank_hold), 0, "R1 hold after reset");
        check_readback("R1");

        // R3 disabled write: stays in bank 0
        do_write(1'b0, 3, 5, 2, 7);
        // R2 enabled write: goes to bank 1 then flips
        do_write(1'b1, 1, 2, 9, 0);
        check(int'(rd_m), 0, "R7 bypass forces M to 0");
        // R6/R7 rate: source 1 (period 3) / 2 -> 100 per 600
        check_rate(600, 100, "R7 bypass rate with divisor R6");
        // R8 fractional: source 2 (period 4), div 1, 3/8 -> 56
        do_write(1'b1, 2, 1, 3, 8);
        check_rate(600, 56, "R8 M/N pulse rate");
        // R6 maximum divisor 16, source 0 (period 2), M=N=1 -> 18
        do_write(1'b1, 0, 16, 1, 1);
        check(int'(rd_div), 16, "R6 maximum divisor readback");
        check_rate(600, 18, "R6 maximum divisor rate");
        // R5 absent code: index 6 reads back 0 and is silent
        do_write(1'b1, 6, 1, 0, 0);
        count_pulses(200, c);
        check(c, 0, "R5 absent source produces no pulses");
        do_write(1'b0, 7, 3, 0, 0);
        check(int'(rd_src), 0, "R5 absent source reads back 0 in place");

        // R10 request while busy is rejected
        out_en = 1'b1;
        wr_src = 3'd4; wr_div = 5'd3; wr_m = 8'd1; wr_n = 8'd2; wr_req = 1'b1;
        @(negedge clk);
        wr_src = 3'd2; wr_div = 5'd9; wr_m = 8'd5; wr_n = 8'd6;
        @(negedge clk);
        wr_req = 1'b0;
        check(int'(wr_rej), 1, "R10 reject pulse while busy");
        @(negedge clk);
        check(int'(wr_rej), 0, "R10 reject lasts one cycle");
        for (int i = 0; i < 100 && busy; i++) @(negedge clk);
        exp_bank = ~exp_bank; exp_src = 4; exp_div = 3; exp_m = 1; exp_n = 2;
        check_readback("R10 first request kept");

        // Constrained random mix
        for (int it = 0; it < 30; it++) begin
            logic en;
            int idx, div, n, m;
            en  = 1'($urandom % 2);
            idx = int'($urandom % 6);
            div = 1 + int'($urandom % 16);
            n   = int'($urandom % 12);
            m   = (n == 0) ? int'($urandom % 4) : 1 + int'($urandom % n);
            do_write(en, idx, div, m, n);
            repeat (int'($urandom % 8)) @(negedge clk);
        end
        report();
    end

endmodule